// File: doc/BRIEF.md
# Iterative Integer Divider

A multi-cycle divide unit for the execute stage of a 64-bit processor. The caller pulses `start` for one cycle. With that pulse it supplies the magnitudes of the dividend and the divisor and five mode flags: signed, word (32-bit), extended, remainder and negate. The caller converts signed operands to magnitudes before the request. It also sets `negate` when the final result must come back as a two's complement. The unit then runs a restoring shift-subtract loop that yields one quotient bit per clock. It returns either the quotient or the remainder on `result`, with a one-cycle `done` pulse.

The unit covers several corner cases. A zero divisor gives a zero result. A quotient that does not fit its signed or unsigned range in extended or word modes is forced to zero. Word-size results are zero-extended, except signed remainders, which are sign-extended from bit 31. The extended modes treat the dividend as the upper half of a double-width value. The unit is busy from the accepted start until its done pulse, and it ignores any start that arrives in that time.

Top module: `div_iter`

## Requirements
- R1: With all mode flags low, `result` is the 64-bit unsigned quotient dividend/divisor. For example, 0x10001000 / 0x1111 returns 0xF001. A second identical request returns the same value.
- R2: A start accepted at clock edge k produces `done` high only in the cycle after edge k+N+1. N is 64 in doubleword modes and 32 in word mode. `done` stays low in every earlier cycle, including the cycle right after the start, and it lasts exactly one cycle.
- R3: A zero divisor returns a result of 0 in every mode. In word mode the divisor is its low 32 bits.
- R4: When `negate` is high, the returned value is the two's complement of the computed quotient or remainder, taken at the operating width (64 or 32 bits). This holds whether or not `is_signed` is set.
- R5: In signed quotient modes the result is 0 when the quotient magnitude is out of range. Out of range means at least 2^(n-1) with `negate` low, or more than 2^(n-1) with `negate` high, where n is the operating width. So the most negative value divided by minus one returns 0.
- R6: In 64-bit extended quotient mode the dividend is the input followed by 64 zero bits. The result is 0 when the dividend input is not below the divisor. R5 applies in signed mode.
- R7: In word quotient mode only the low 32 bits of both operands are used, and the 32-bit quotient is zero-extended to 64 bits.
- R8: In word extended quotient mode the dividend is dividend[31:0] followed by 32 zero bits, over divisor[31:0]. The result is 0 unless divisor[31:0] > dividend[31:0], and R5 applies in signed mode. The quotient is zero-extended.
- R9: In remainder mode the result is the remainder of the non-extended division, and `is_ext` has no effect. A word remainder uses the low 32 bits of both operands. A signed word remainder is sign-extended from bit 31, and an unsigned word remainder is zero-extended.
- R10: A `start` that arrives while the unit is busy has no effect. The running operation completes with its own result, and no extra `done` follows.
- R11: Reset clears the busy state, `done` and `result` (to 0). An operation cut off by reset never signals `done`.
- R12: A start asserted in the same cycle as `done` is accepted. Its result follows with the R2 timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| dividend | input | 64 | Dividend magnitude |
| divisor | input | 64 | Divisor magnitude |
| is_signed | input | 1 | Signed range checks and signed word remainder extension |
| is_word | input | 1 | 32-bit operation on the low operand words |
| is_ext | input | 1 | Extended dividend (upper half of a double-width value) |
| is_mod | input | 1 | Return the remainder instead of the quotient |
| negate | input | 1 | Return the two's complement of the result |
| done | output | 1 | One-cycle completion strobe |
| result | output | 64 | Quotient or remainder, held until the next completion |

## Verification
Two events can fall in the same cycle: the completion of one operation and the arrival of the next start. The unit must deliver the first result and accept the new request in that cycle. The bench provokes this by raising `start` with new operands during the cycle in which `done` is high. It first checks that the old result is present there. It then checks that `done` drops at once and that the second result arrives exactly N+1 cycles after that edge. A related collision, a start that arrives while busy, is provoked in the middle of a run. It is judged by checking that the original result arrives on time and that no second `done` follows.

// File: rtl/div_iter_pkg.sv
package div_iter_pkg;

    // Mode flags captured at an accepted start
    typedef struct packed {
        logic sgn;
        logic word;
        logic ext;
        logic modu;
        logic neg;
    } div_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } div_state_t;

endpackage

// File: rtl/div_prep.sv
// Builds the initial partial remainder, shift register and divisor for a request.
module div_prep
    import div_iter_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         is_signed,
    input  logic         is_word,
    input  logic         is_ext,
    input  logic         is_mod,
    input  logic         negate,
    output logic [W-1:0] rem0,
    output logic [W-1:0] qsh0,
    output logic [W-1:0] den0,
    output logic         zero_div,
    output logic         ext_ovf,
    output div_mode_t    mode
);
    localparam int HALF = W / 2;

    logic [W-1:0] dnum;
    logic         ext_eff;

    always_comb begin
        ext_eff = is_ext & ~is_mod;
        dnum    = is_word ? {{HALF{1'b0}}, dividend[HALF-1:0]} : dividend;
        den0    = is_word ? {{HALF{1'b0}}, divisor[HALF-1:0]}  : divisor;

        if (ext_eff) begin
            // dividend sits in the upper half: start with it as partial remainder
            rem0 = dnum;
            qsh0 = '0;
        end else begin
            rem0 = '0;
            qsh0 = is_word ? {dividend[HALF-1:0], {HALF{1'b0}}} : dividend;
        end

        zero_div = (den0 == '0);
        ext_ovf  = ext_eff & (dnum >= den0);

        mode.sgn  = is_signed;
        mode.word = is_word;
        mode.ext  = ext_eff;
        mode.modu = is_mod;
        mode.neg  = negate;
    end
endmodule

// File: rtl/div_step.sv
// One restoring shift-subtract iteration.
module div_step #(
    parameter int W = 64
) (
    input  logic [W-1:0] rem_i,
    input  logic [W-1:0] quo_i,
    input  logic [W-1:0] den_i,
    output logic [W-1:0] rem_o,
    output logic [W-1:0] quo_o
);
    logic [W:0] trial;
    logic [W:0] diff;
    logic       qbit;

    always_comb begin
        trial = {rem_i, quo_i[W-1]};
        diff  = trial - {1'b0, den_i};
        qbit  = ~diff[W];
        rem_o = qbit ? diff[W-1:0] : trial[W-1:0];
        quo_o = {quo_i[W-2:0], qbit};
    end
endmodule

// File: rtl/div_fixup.sv
// Range checks, sign fix-up and word extension of the final value.
module div_fixup
    import div_iter_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] quo,
    input  logic [W-1:0] rem,
    input  div_mode_t    mode,
    input  logic         zero_div,
    input  logic         ext_ovf,
    output logic [W-1:0] res
);
    localparam int HALF = W / 2;

    logic [HALF-1:0] r_word;
    logic [HALF-1:0] q_word;
    logic            ovf_full;
    logic            ovf_word;
    logic            ovf;

    always_comb begin
        // magnitude 2^(n-1) is only representable as a negative value
        ovf_full = mode.neg ? (quo[W-1] & (|quo[W-2:0]))       : quo[W-1];
        ovf_word = mode.neg ? (quo[HALF-1] & (|quo[HALF-2:0])) : quo[HALF-1];
        ovf      = mode.sgn & ~mode.modu & (mode.word ? ovf_word : ovf_full);

        r_word = mode.neg ? (~rem[HALF-1:0] + 1'b1) : rem[HALF-1:0];
        q_word = mode.neg ? (~quo[HALF-1:0] + 1'b1) : quo[HALF-1:0];

        if (mode.modu) begin
            if (mode.word) begin
                res = {(mode.sgn ? {HALF{r_word[HALF-1]}} : {HALF{1'b0}}), r_word};
            end else begin
                res = mode.neg ? (~rem + 1'b1) : rem;
            end
        end else begin
            if (mode.word) begin
                res = {{HALF{1'b0}}, q_word};
            end else begin
                res = mode.neg ? (~quo + 1'b1) : quo;
            end
        end

        if (zero_div | ext_ovf | ovf) begin
            res = '0;
        end
    end
endmodule

// File: rtl/div_iter.sv
module div_iter
    import div_iter_pkg::*;
#(
    parameter int W     = 64,
    parameter int STEPS = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    input  logic         is_signed,
    input  logic         is_word,
    input  logic         is_ext,
    input  logic         is_mod,
    input  logic         negate,
    output logic         done,
    output logic [W-1:0] result
);
    localparam int HALF    = W / 2;
    localparam int FULL_IT = W / STEPS;
    localparam int HALF_IT = HALF / STEPS;
    localparam int CW      = $clog2(FULL_IT + 1);

    typedef struct packed {
        div_state_t   st;
        logic [CW-1:0] cnt;
        logic [W-1:0] rem;
        logic [W-1:0] qsh;
        logic [W-1:0] den;
        div_mode_t    mode;
        logic         zero_div;
        logic         ext_ovf;
        logic         done;
        logic [W-1:0] res;
    } regs_t;

    regs_t regs_d, regs_q;

    logic         busy;
    logic [W-1:0] p_rem, p_qsh, p_den;
    logic         p_zero, p_ovf;
    div_mode_t    p_mode;
    logic [W-1:0] fix_res;

    logic [W-1:0] r_ch [STEPS+1];
    logic [W-1:0] q_ch [STEPS+1];

    div_prep #(.W(W)) u_prep (
        .dividend (dividend),
        .divisor  (divisor),
        .is_signed(is_signed),
        .is_word  (is_word),
        .is_ext   (is_ext),
        .is_mod   (is_mod),
        .negate   (negate),
        .rem0     (p_rem),
        .qsh0     (p_qsh),
        .den0     (p_den),
        .zero_div (p_zero),
        .ext_ovf  (p_ovf),
        .mode     (p_mode)
    );

    assign r_ch[0] = regs_q.rem;
    assign q_ch[0] = regs_q.qsh;

    for (genvar s = 0; s < STEPS; s++) begin : g_step
        div_step #(.W(W)) u_step (
            .rem_i(r_ch[s]),
            .quo_i(q_ch[s]),
            .den_i(regs_q.den),
            .rem_o(r_ch[s+1]),
            .quo_o(q_ch[s+1])
        );
    end

    div_fixup #(.W(W)) u_fix (
        .quo     (regs_q.qsh),
        .rem     (regs_q.rem),
        .mode    (regs_q.mode),
        .zero_div(regs_q.zero_div),
        .ext_ovf (regs_q.ext_ovf),
        .res     (fix_res)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.done = 1'b0;
        unique case (regs_q.st)
            ST_IDLE: begin
                if (start) begin
                    regs_d.st       = ST_RUN;
                    regs_d.cnt      = is_word ? CW'(HALF_IT) : CW'(FULL_IT);
                    regs_d.rem      = p_rem;
                    regs_d.qsh      = p_qsh;
                    regs_d.den      = p_den;
                    regs_d.mode     = p_mode;
                    regs_d.zero_div = p_zero;
                    regs_d.ext_ovf  = p_ovf;
                end
            end
            ST_RUN: begin
                regs_d.rem = r_ch[STEPS];
                regs_d.qsh = q_ch[STEPS];
                regs_d.cnt = regs_q.cnt - 1'b1;
                if (regs_q.cnt == CW'(1)) begin
                    regs_d.st = ST_FIX;
                end
            end
            ST_FIX: begin
                regs_d.res  = fix_res;
                regs_d.done = 1'b1;
                regs_d.st   = ST_IDLE;
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign busy   = (regs_q.st != ST_IDLE);
    assign done   = regs_q.done;
    assign result = regs_q.res;

endmodule

// File: rtl/div_iter_chk.sv
module div_iter_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic [W-1:0] result,
    input logic [W-1:0] divisor,
    input logic         is_word
);
    localparam int HALF = W / 2;
    localparam int LIM  = W + 2;

    logic       accept;
    logic       zlat;
    logic       pending;
    logic [7:0] lat;

    assign accept = start & ~busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            zlat    <= 1'b0;
            pending <= 1'b0;
            lat     <= '0;
        end else begin
            if (accept) begin
                zlat    <= is_word ? (divisor[HALF-1:0] == '0) : (divisor == '0);
                pending <= 1'b1;
                lat     <= 8'd1;
            end else begin
                if (done) pending <= 1'b0;
                if (busy && lat != 8'hFF) lat <= lat + 8'd1;
            end
        end
    end

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_quiet_after_start_R2: assert property (@(posedge clk) disable iff (rst)
        accept |=> !done);

    assert_latency_bound_R2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (lat <= 8'(LIM)));

    assert_zero_divisor_R3: assert property (@(posedge clk) disable iff (rst)
        (done && zlat) |-> (result == '0));

    assert_single_done_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> pending);

    assert_reset_clears_R11: assert property (@(posedge clk)
        rst |=> (!done && !busy && result == '0));

endmodule

bind div_iter div_iter_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .busy   (busy),
    .done   (done),
    .result (result),
    .divisor(divisor),
    .is_word(is_word)
);

// File: tb/div_iter_test.sv
module div_iter_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [63:0] dividend, divisor;
    logic        is_signed, is_word, is_ext, is_mod, negate;
    logic        done;
    logic [63:0] result;

    int checks   = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    div_iter uut (
        .clk(clk), .rst(rst), .start(start),
        .dividend(dividend), .divisor(divisor),
        .is_signed(is_signed), .is_word(is_word), .is_ext(is_ext),
        .is_mod(is_mod), .negate(negate),
        .done(done), .result(result)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Arithmetic reference built from the requirements
    function automatic logic [63:0] ref_val(input logic [63:0] d, input logic [63:0] v,
                                            input logic sg, input logic wd, input logic ex,
                                            input logic md, input logic ng);
        logic [127:0] num, den, q, lim, half;
        logic [31:0]  r32;
        logic [63:0]  r64;
        int n;
        if (wd ? (v[31:0] == 32'd0) : (v == 64'd0)) return 64'd0;
        if (md) begin
            if (wd) begin
                r32 = d[31:0] % v[31:0];
                if (ng) r32 = 32'd0 - r32;
                return sg ? {{32{r32[31]}}, r32} : {32'd0, r32};
            end
            r64 = d % v;
            return ng ? (64'd0 - r64) : r64;
        end
        n    = wd ? 32 : 64;
        num  = ex ? (wd ? {64'd0, d[31:0], 32'd0} : {d, 64'd0})
                  : (wd ? {96'd0, d[31:0]} : {64'd0, d});
        den  = wd ? {96'd0, v[31:0]} : {64'd0, v};
        q    = num / den;
        lim  = 128'd1 << n;
        half = 128'd1 << (n - 1);
        if (!sg && q >= lim) return 64'd0;
        if (sg && (ng ? (q > half) : (q >= half))) return 64'd0;
        if (ng) q = (lim - q) & (lim - 128'd1);
        return q[63:0];
    endfunction

    function automatic string tag_of(input logic [63:0] v, input logic wd, input logic ex, input logic md);
        if (wd ? (v[31:0] == 32'd0) : (v == 64'd0)) return "R3";
        if (md) return "R9";
        if (ex && wd) return "R8";
        if (ex) return "R6";
        if (wd) return "R7";
        return "R1";
    endfunction

    task automatic drive(input logic [63:0] d, input logic [63:0] v, input logic sg, input logic wd,
                         input logic ex, input logic md, input logic ng);
        dividend = d; divisor = v; is_signed = sg; is_word = wd;
        is_ext = ex; is_mod = md; negate = ng;
    endtask

    // Called at the negedge right after the accepting edge
    task automatic finish_op(input int n, input logic [63:0] exp, input string req, input bit check_tail);
        bit early = 1'b0;
        for (int k = 1; k <= n + 1; k++) begin
            if (done) early = 1'b1;
            @(negedge clk);
        end
        chk(!early && done, "R2 done timing", {63'd0, done}, 64'd1);
        chk(result == exp, req, result, exp);
        if (check_tail) begin
            @(negedge clk);
            chk(!done, "R2 done width", {63'd0, done}, 64'd0);
        end
    endtask

    task automatic run_op(input logic [63:0] d, input logic [63:0] v, input logic sg, input logic wd,
                          input logic ex, input logic md, input logic ng, input string req);
        logic [63:0] exp;
        exp = ref_val(d, v, sg, wd, ex, md, ng);
        @(negedge clk);
        drive(d, v, sg, wd, ex, md, ng);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        finish_op(wd ? 32 : 64, exp, req, 1'b1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] d, v;
        logic        ng;
        rst = 1'b1;
        start = 1'b0;
        drive(64'd0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk(!done && result == 64'd0, "R11 reset state", result, 64'd0);
        rst = 1'b0;

        // R1 worked example, twice
        run_op(64'h10001000, 64'h1111, 0, 0, 0, 0, 0, "R1 quotient");
        run_op(64'h10001000, 64'h1111, 0, 0, 0, 0, 0, "R1 repeat");
        chk(result == 64'hF001, "R1 literal", result, 64'hF001);

        // R4 negate
        run_op(64'd100, 64'd7, 0, 0, 0, 0, 1, "R4 negate quotient");
        run_op(64'd100, 64'd7, 1, 0, 0, 1, 1, "R4 negate remainder");

        // R5 signed range
        run_op(64'h8000000000000000, 64'd1, 1, 0, 0, 0, 0, "R5 min over minus one");
        run_op(64'h8000000000000000, 64'd1, 1, 0, 0, 0, 1, "R5 min over one");
        run_op(64'h80000000, 64'd1, 1, 1, 0, 0, 0, "R5 word min over minus one");

        // R6 extended doubleword
        run_op(64'd1, 64'd2, 0, 0, 1, 0, 0, "R6 extended unsigned");
        run_op(64'd5, 64'd5, 0, 0, 1, 0, 0, "R6 dividend not below divisor");
        run_op(64'd1, 64'd2, 1, 0, 1, 0, 0, "R6 extended signed overflow");
        run_op(64'd1, 64'd2, 1, 0, 1, 0, 1, "R6 extended signed negative limit");

        // R7, R8 word modes
        run_op(64'hFFFF_FFFF_0000_0064, 64'hFFFF_0000_0000_000A, 0, 1, 0, 0, 0, "R7 word low halves");
        run_op(64'd1, 64'd2, 0, 1, 1, 0, 0, "R8 word extended unsigned");
        run_op(64'd1, 64'd2, 1, 1, 1, 0, 1, "R8 word extended signed");
        run_op(64'd3, 64'd3, 0, 1, 1, 0, 0, "R8 divisor not above dividend");

        // R9 remainder modes, ext ignored
        run_op(64'd7, 64'd2, 1, 1, 0, 1, 1, "R9 signed word remainder extension");
        run_op(64'hF000_0000, 64'hF000_0001, 0, 1, 0, 1, 0, "R9 unsigned word remainder");
        run_op(64'd1000, 64'd33, 0, 0, 1, 1, 0, "R9 ext flag ignored");

        // R3 zero divisor
        run_op(64'd12345, 64'd0, 1, 0, 0, 1, 1, "R3 remainder by zero");
        run_op(64'd12345, 64'hFFFF_FFFF_0000_0000, 0, 1, 0, 0, 0, "R3 word divisor zero");

        // Sweep over all mode combinations
        for (int m = 0; m < 16; m++) begin
            for (int i = 0; i < 28; i++) begin
                d  = {$urandom, $urandom} >> ($urandom % 64);
                v  = {$urandom, $urandom} >> ($urandom % 64);
                if (i % 9 == 0) v = 64'd0;
                if (i % 7 == 1) v = d + 64'd1;
                if (i % 7 == 2) v = d;
                ng = 1'($urandom % 2);
                run_op(d, v, m[0], m[1], m[2], m[3], ng, tag_of(v, m[1], m[2], m[3]));
            end
        end

        // R12 start in the done cycle
        begin
            logic [63:0] exp_b;
            exp_b = ref_val(64'd999, 64'd10, 0, 0, 0, 1, 0);
            @(negedge clk);
            drive(64'd5000, 64'd3, 0, 0, 0, 0, 0);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            for (int k = 1; k <= 65; k++) @(negedge clk);
            chk(done && result == 64'd1666, "R12 first result at collision", result, 64'd1666);
            drive(64'd999, 64'd10, 0, 0, 0, 1, 0);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            finish_op(64, exp_b, "R12 second result", 1'b1);
        end

        // R10 start while busy
        @(negedge clk);
        drive(64'd1000, 64'd10, 0, 0, 0, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        drive(64'd7, 64'd0, 0, 1, 0, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 7; k <= 65; k++) @(negedge clk);
        chk(done && result == 64'd100, "R10 busy start ignored", result, 64'd100);
        begin
            bit extra = 1'b0;
            for (int k = 0; k < 70; k++) begin
                @(negedge clk);
                if (done) extra = 1'b1;
            end
            chk(!extra, "R10 no extra done", {63'd0, extra}, 64'd0);
        end

        // R11 reset during a run
        drive(64'd77, 64'd7, 0, 0, 0, 0, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk(!done && result == 64'd0, "R11 reset clears result", result, 64'd0);
        begin
            bit seen = 1'b0;
            for (int k = 0; k < 70; k++) begin
                @(negedge clk);
                if (done) seen = 1'b1;
            end
            chk(!seen, "R11 aborted run silent", {63'd0, seen}, 64'd0);
        end
        run_op(64'd77, 64'd7, 0, 0, 0, 0, 0, "R11 usable after reset");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule